// File: doc/BRIEF.md
# Transfer Job Ring Scheduler

This block schedules transfer jobs for one copy engine. A client submits jobs. Each accepted job takes one of a fixed number of ring slots and gets a sequence handle, which is one more than the previous handle. When the engine is idle and at least one job is waiting, the scheduler starts the oldest waiting job. It then watches the engine's done and enable status to decide when the job has finished.

A job can run for longer than a cycle budget set by a parameter. In that case the scheduler issues an abort and re-arms its timer. It then treats the engine's enable going low as an alternate kind of completion, and marks that job as aborted. A finished slot goes back into the free pool only when the client releases it, and slots are released in order.

A query port reports whether any handle is still pending. It compares handles modulo the handle width inside a window, so the answer stays correct after the handle counter wraps.

Top module: `blit_ring_sched`

## Requirements
- R1: After reset, free_count equals SLOTS, sub_ready is 1, eng_off is 1, eng_start is 0, and handle 1 reads as not pending.
- R2: A submit is accepted when sub_valid is high and free_count is non-zero. The handle shown on sub_handle is the previous issued handle plus one, modulo 2^HW, and the first handle after reset is 1. A refused submit uses up no handle.
- R3: q_pending is 1 exactly when (done − q) > 2^WIN_LOG and (issued − q) ≤ 2^WIN_LOG, with both differences taken modulo 2^HW. Here done is the count of finished jobs and issued is the last handle given out. This stays correct after the handles wrap.
- R4: A job finishes in the cycle where a job is active and eng_done is 1. In that cycle fin_valid and done_clear pulse, and fin_handle carries the job's handle. Jobs finish in the order they were submitted.
- R5: When no job is active and jobs are waiting, eng_start pulses and eng_slot names the oldest waiting slot. Slot indices advance by one and wrap at SLOTS. When no job is active and none is waiting, eng_off is 1.
- R6: If a job is still active TIMEOUT_CYC cycles after its eng_start pulse, eng_abort pulses in that cycle. The job then finishes in the first cycle where eng_enable is 0, with fin_aborted equal to 1.
- R7: free_count drops by one on each accepted submit and is never returned when a job finishes. It rises by one only when rel_req releases a finished slot (rel_valid 1). A release with no finished slot waiting has no effect. While free_count is 0, sub_ready is 0 and nothing is accepted.
- R8: Each slot keeps the aborted state of its last finished job. rel_aborted shows that flag for the slot being released, and rel_slot shows the slot index. Releases run in completion order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sub_valid | input | 1 | Submit request |
| sub_ready | output | 1 | A free slot exists |
| sub_accept | output | 1 | Submit taken this cycle |
| sub_handle | output | HW | Handle given to the job being submitted |
| sub_slot | output | SW | Ring slot the submitted job occupies |
| free_count | output | FW | Slots not held by any job |
| eng_start | output | 1 | Start pulse to the engine |
| eng_slot | output | SW | Slot of the job currently at the engine |
| eng_abort | output | 1 | Abort pulse to the engine |
| eng_off | output | 1 | Engine may be switched off (idle, nothing waiting) |
| done_clear | output | 1 | Clears the engine's transfer-done status |
| eng_done | input | 1 | Engine transfer-done status |
| eng_enable | input | 1 | Engine enable status |
| fin_valid | output | 1 | A job finished this cycle |
| fin_handle | output | HW | Handle of the finishing job |
| fin_aborted | output | 1 | The finishing job was aborted |
| rel_req | input | 1 | Release the oldest finished slot |
| rel_valid | output | 1 | A release took effect this cycle |
| rel_slot | output | SW | Slot being released |
| rel_aborted | output | 1 | Aborted flag of the slot being released |
| q_handle | input | HW | Handle to query |
| q_pending | output | 1 | Queried handle is still pending |

## Verification
The bench builds the block with HW = 6 and WIN_LOG = 4, which makes handles wrap after 64 jobs. Because of this, the bench can run the counter past its wrap point and then check pending answers on both sides of it. TIMEOUT_CYC = 20 makes the abort path reachable in a short run, so the bench can measure the gap from eng_start to eng_abort exactly. SLOTS stays at 8, so the bench can fill the ring, try a refused submit, and see slot indices wrap.

// File: rtl/blit_sched_pkg.sv
// Package: types shared by the transfer job ring scheduler.
// Assumes nothing beyond IEEE 1800-2017.
package blit_sched_pkg;

    // Engine-side phase of the scheduler.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RUN   = 2'd1,
        PH_ABORT = 2'd2
    } phase_t;

endpackage

// File: rtl/blit_ring_ptr.sv
// Module: blit_ring_ptr
// A ring index that steps forward by one on adv and wraps from SLOTS-1 to 0.
// Assumes SLOTS >= 2.
module blit_ring_ptr #(
    parameter int SLOTS = 8,
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [SW-1:0] idx
);
    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

    // Step the index, wrapping at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (adv)
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/blit_handle_ctr.sv
// Module: blit_handle_ctr
// Holds the issued and retired sequence handles and answers the pending
// query with a modular window compare that survives wraparound.
// Assumes WIN_LOG < HW.
module blit_handle_ctr #(
    parameter int HW      = 32,
    parameter int WIN_LOG = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic          retire,
    output logic [HW-1:0] cur_h,
    output logic [HW-1:0] done_h,
    input  logic [HW-1:0] q_handle,
    output logic          q_pending
);
    localparam logic [HW-1:0] WIN = HW'(1) << WIN_LOG;

    logic [HW-1:0] since_done;
    logic [HW-1:0] since_issue;

    // Count handles handed out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_h <= '0;
        else if (issue)
            cur_h <= cur_h + 1'b1;
    end

    // Count handles completed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_h <= '0;
        else if (retire)
            done_h <= done_h + 1'b1;
    end

    // Modular distance compare for the query port.
    always_comb begin
        since_done  = done_h - q_handle;
        since_issue = cur_h - q_handle;
        q_pending   = (since_done > WIN) && (since_issue <= WIN);
    end
endmodule

// File: rtl/blit_timeout.sv
// Module: blit_timeout
// Down-counter for the per-job cycle budget. arm reloads it; run counts
// down toward zero; expired is high at zero. Assumes TIMEOUT_CYC >= 2.
module blit_timeout #(
    parameter int TIMEOUT_CYC = 100000,
    localparam int TW = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic run,
    output logic expired
);
    localparam logic [TW-1:0] RELOAD = TW'(TIMEOUT_CYC - 1);

    logic [TW-1:0] cnt;

    // Reload on arm, otherwise count down while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= RELOAD;
        else if (arm)
            cnt <= RELOAD;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/blit_ring_sched.sv
// Module: blit_ring_sched
// Per-engine job scheduler: a ring of SLOTS job slots with separate
// submit, engine and release indices, sequence handles, a timeout abort
// path and a pending-handle query. Assumes the engine holds eng_done until
// done_clear and drops eng_enable some time after an abort.
module blit_ring_sched #(
    parameter int SLOTS       = 8,
    parameter int HW          = 32,
    parameter int WIN_LOG     = 23,
    parameter int TIMEOUT_CYC = 100000,
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int FW = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sub_valid,
    output logic          sub_ready,
    output logic          sub_accept,
    output logic [HW-1:0] sub_handle,
    output logic [SW-1:0] sub_slot,
    output logic [FW-1:0] free_count,
    output logic          eng_start,
    output logic [SW-1:0] eng_slot,
    output logic          eng_abort,
    output logic          eng_off,
    output logic          done_clear,
    input  logic          eng_done,
    input  logic          eng_enable,
    output logic          fin_valid,
    output logic [HW-1:0] fin_handle,
    output logic          fin_aborted,
    input  logic          rel_req,
    output logic          rel_valid,
    output logic [SW-1:0] rel_slot,
    output logic          rel_aborted,
    input  logic [HW-1:0] q_handle,
    output logic          q_pending
);
    import blit_sched_pkg::*;

    phase_t        phase_q;
    logic          active;
    logic          aborting;
    logic          done_xfer;
    logic          expired;
    logic [FW-1:0] outst_q;
    logic [FW-1:0] fin_cnt_q;
    logic [HW-1:0] cur_h;
    logic [HW-1:0] done_h;
    logic [SW-1:0] head_idx;
    logic [SW-1:0] cur_idx;
    logic [SW-1:0] serv_idx;
    logic [SLOTS-1:0] abt_flag;

    // Decode the engine phase and the completion condition.
    always_comb begin
        active    = (phase_q != PH_IDLE);
        aborting  = (phase_q == PH_ABORT);
        done_xfer = (active && eng_done) || (aborting && !eng_enable);
    end

    // Submit side handshake.
    always_comb begin
        sub_ready  = (free_count != '0);
        sub_accept = sub_valid && sub_ready;
        sub_handle = cur_h + 1'b1;
        sub_slot   = head_idx;
    end

    // Engine side controls.
    always_comb begin
        eng_start  = !active && (outst_q != '0);
        eng_off    = !active && (outst_q == '0);
        eng_abort  = active && !done_xfer && expired;
        eng_slot   = cur_idx;
        done_clear = done_xfer;
    end

    // Completion and release reporting.
    always_comb begin
        fin_valid   = done_xfer;
        fin_handle  = done_h + 1'b1;
        fin_aborted = aborting;
        rel_valid   = rel_req && (fin_cnt_q != '0);
        rel_slot    = serv_idx;
        rel_aborted = abt_flag[serv_idx];
    end

    // Engine phase: finish wins, then abort, then start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_IDLE;
        else if (done_xfer)
            phase_q <= PH_IDLE;
        else if (eng_abort)
            phase_q <= PH_ABORT;
        else if (eng_start)
            phase_q <= PH_RUN;
    end

    // Jobs submitted but not yet started.
    always_ff @(posedge clk) begin
        if (!rst_n)
            outst_q <= '0;
        else
            outst_q <= outst_q + FW'(sub_accept) - FW'(eng_start);
    end

    // Slots not held by any job; only a release returns one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            free_count <= FW'(SLOTS);
        else
            free_count <= free_count - FW'(sub_accept) + FW'(rel_valid);
    end

    // Finished slots waiting for release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fin_cnt_q <= '0;
        else
            fin_cnt_q <= fin_cnt_q + FW'(done_xfer) - FW'(rel_valid);
    end

    // Per-slot aborted flag written at completion.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                abt_flag[s] <= 1'b0;
            else if (done_xfer && cur_idx == SW'(s))
                abt_flag[s] <= aborting;
        end
    end

    blit_ring_ptr #(.SLOTS(SLOTS)) u_head (
        .clk(clk), .rst_n(rst_n), .adv(sub_accept), .idx(head_idx)
    );

    blit_ring_ptr #(.SLOTS(SLOTS)) u_cur (
        .clk(clk), .rst_n(rst_n), .adv(done_xfer), .idx(cur_idx)
    );

    blit_ring_ptr #(.SLOTS(SLOTS)) u_serv (
        .clk(clk), .rst_n(rst_n), .adv(rel_valid), .idx(serv_idx)
    );

    blit_handle_ctr #(.HW(HW), .WIN_LOG(WIN_LOG)) u_hnd (
        .clk(clk), .rst_n(rst_n), .issue(sub_accept), .retire(done_xfer),
        .cur_h(cur_h), .done_h(done_h), .q_handle(q_handle),
        .q_pending(q_pending)
    );

    blit_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
        .clk(clk), .rst_n(rst_n), .arm(eng_start || eng_abort),
        .run(active && !done_xfer), .expired(expired)
    );
endmodule

// File: rtl/blit_ring_sched_chk.sv
// Module: blit_ring_sched_chk
// Assertion checker bound to blit_ring_sched; observes ports and state.
module blit_ring_sched_chk #(
    parameter int SLOTS = 8,
    parameter int HW    = 32,
    localparam int FW = $clog2(SLOTS + 1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         sub_accept,
    input logic [HW-1:0]                sub_handle,
    input logic                         eng_start,
    input logic                         eng_abort,
    input logic                         fin_valid,
    input logic [FW-1:0]                free_count,
    input logic [HW-1:0]                cur_h,
    input logic [HW-1:0]                done_h,
    input blit_sched_pkg::phase_t       phase_q
);
    import blit_sched_pkg::*;

    // R2: the handle shown at accept becomes the issued handle.
    a_r2_handle_issued: assert property (@(posedge clk) disable iff (!rst_n)
        sub_accept |=> cur_h == $past(sub_handle));

    // R4: each completion retires exactly one handle.
    a_r4_done_step: assert property (@(posedge clk) disable iff (!rst_n)
        fin_valid |=> done_h == HW'($past(done_h) + 1'b1));

    // R4: completion leaves the engine idle.
    a_r4_fin_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fin_valid |=> phase_q == PH_IDLE);

    // R5: a start is a single-cycle pulse.
    a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R6: an abort moves the engine into the aborting phase.
    a_r6_abort_phase: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |=> phase_q == PH_ABORT);

    // R7: free slots never exceed the ring size.
    a_r7_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
        free_count <= FW'(SLOTS));
endmodule

bind blit_ring_sched blit_ring_sched_chk #(.SLOTS(SLOTS), .HW(HW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sub_accept(sub_accept),
    .sub_handle(sub_handle), .eng_start(eng_start), .eng_abort(eng_abort),
    .fin_valid(fin_valid), .free_count(free_count), .cur_h(cur_h),
    .done_h(done_h), .phase_q(phase_q)
);

// File: tb/blit_ring_sched_tb.sv
module blit_ring_sched_tb;
    localparam int SLOTS = 8;
    localparam int HW    = 6;
    localparam int WINL  = 4;
    localparam int TMO   = 20;
    localparam int SW    = 3;
    localparam int FW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sub_valid = 1'b0;
    logic          sub_ready, sub_accept;
    logic [HW-1:0] sub_handle;
    logic [SW-1:0] sub_slot;
    logic [FW-1:0] free_count;
    logic          eng_start, eng_abort, eng_off, done_clear;
    logic [SW-1:0] eng_slot;
    logic          eng_done = 1'b0;
    logic          eng_enable = 1'b0;
    logic          fin_valid, fin_aborted;
    logic [HW-1:0] fin_handle;
    logic          rel_req = 1'b0;
    logic          rel_valid, rel_slot_unused, rel_aborted;
    logic [SW-1:0] rel_slot;
    logic [HW-1:0] q_handle = '0;
    logic          q_pending;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_h = 0;
    int start_cyc = 0;
    int exp_start_slot = 0;
    int exp_rel_slot = 0;
    int sb_h[$];
    bit sb_ab[$];
    int lat_q[$];

    bit e_busy = 0, e_clr = 0, e_abt = 0;
    int e_cnt = 0;

    assign rel_slot_unused = 1'b0;

    always #5 clk = ~clk;

    blit_ring_sched #(.SLOTS(SLOTS), .HW(HW), .WIN_LOG(WINL), .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_ready(sub_ready),
        .sub_accept(sub_accept), .sub_handle(sub_handle), .sub_slot(sub_slot),
        .free_count(free_count), .eng_start(eng_start), .eng_slot(eng_slot),
        .eng_abort(eng_abort), .eng_off(eng_off), .done_clear(done_clear),
        .eng_done(eng_done), .eng_enable(eng_enable), .fin_valid(fin_valid),
        .fin_handle(fin_handle), .fin_aborted(fin_aborted), .rel_req(rel_req),
        .rel_valid(rel_valid), .rel_slot(rel_slot), .rel_aborted(rel_aborted),
        .q_handle(q_handle), .q_pending(q_pending)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Engine model: drives status at the falling edge.
    always @(negedge clk) begin
        if (e_clr) begin eng_done = 1'b0; e_clr = 0; end
        if (e_abt) begin e_busy = 0; e_abt = 0; end
        if (e_busy) begin
            if (e_cnt <= 1) begin eng_done = 1'b1; e_busy = 0; end
            else e_cnt--;
        end
        eng_enable = e_busy;
    end

    // Monitor: samples outputs late in the low phase, scoreboard compare.
    always @(negedge clk) begin
        #3;
        cyc++;
        if (rst_n) begin
            if (eng_start) begin
                check("R5 start slot", int'(eng_slot), exp_start_slot);
                exp_start_slot = (exp_start_slot + 1) % SLOTS;
                start_cyc = cyc;
                e_busy = 1;
                e_cnt = (lat_q.size() != 0) ? lat_q.pop_front() : 1;
            end
            if (eng_abort) begin
                check("R6 abort delay", cyc - start_cyc, TMO);
                e_abt = 1;
            end
            if (done_clear) e_clr = 1;
            if (fin_valid) begin
                if (sb_h.size() == 0) begin
                    check("R4 unexpected finish", 1, 0);
                end else begin
                    check("R4 finish handle", int'(fin_handle), sb_h.pop_front());
                    check("R6 finish aborted", int'(fin_aborted), int'(sb_ab.pop_front()));
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Driver: submit one job, push expectation into the scoreboard.
    task automatic submit(input int lat, input bit ab);
        @(negedge clk);
        while (!sub_ready) @(negedge clk);
        lat_q.push_back(lat);
        sub_valid = 1'b1;
        #1;
        exp_h = (exp_h + 1) % 64;
        check("R2 accept", int'(sub_accept), 1);
        check("R2 handle", int'(sub_handle), exp_h);
        sb_h.push_back(exp_h);
        sb_ab.push_back(ab);
        @(posedge clk);
        #1 sub_valid = 1'b0;
    endtask

    task automatic release_one(input bit exp_ab);
        @(negedge clk);
        rel_req = 1'b1;
        #1;
        check("R7 release valid", int'(rel_valid), 1);
        check("R8 release slot", int'(rel_slot), exp_rel_slot);
        check("R8 release aborted", int'(rel_aborted), int'(exp_ab));
        exp_rel_slot = (exp_rel_slot + 1) % SLOTS;
        @(posedge clk);
        #1 rel_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            #4;
            if (sb_h.size() == 0 && eng_off) break;
        end
        @(negedge clk);
    endtask

    task automatic query(input int h, input int exp, input string req);
        @(negedge clk);
        q_handle = HW'(h);
        #1;
        check(req, int'(q_pending), exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 free", int'(free_count), SLOTS);
        check("R1 ready", int'(sub_ready), 1);
        check("R1 off", int'(eng_off), 1);
        check("R1 start", int'(eng_start), 0);
        query(1, 0, "R1 pending after reset");

        // Normal jobs.
        submit(3, 0);
        submit(5, 0);
        submit(2, 0);
        query(3, 1, "R3 newest pending");
        wait_idle();
        query(1, 0, "R3 done not pending");
        check("R5 off when empty", int'(eng_off), 1);
        check("R7 free kept until release", int'(free_count), SLOTS - 3);
        for (int i = 0; i < 3; i++) release_one(0);
        check("R7 free restored", int'(free_count), SLOTS);
        @(negedge clk);
        rel_req = 1'b1;
        #1 check("R7 empty release ignored", int'(rel_valid), 0);
        @(posedge clk); #1 rel_req = 1'b0;
        @(negedge clk); #1 check("R7 free unchanged", int'(free_count), SLOTS);

        // Timeout and abort.
        submit(100, 1);
        submit(2, 0);
        wait_idle();
        release_one(1);
        release_one(0);

        // Fill the ring.
        for (int i = 0; i < SLOTS; i++) submit(15, 0);
        @(negedge clk);
        sub_valid = 1'b1;
        #1;
        check("R7 full not ready", int'(sub_ready), 0);
        check("R7 full no accept", int'(sub_accept), 0);
        repeat (3) @(negedge clk);
        #1 check("R7 full stays zero", int'(free_count), 0);
        sub_valid = 1'b0;
        wait_idle();
        for (int i = 0; i < SLOTS; i++) release_one(0);

        // Run handles up to the wrap point.
        while (exp_h != 62) begin
            submit(1, 0);
            wait_idle();
            release_one(0);
        end
        submit(10, 0);
        submit(10, 0);
        submit(10, 0);
        check("R2 wrapped handle", exp_h, 1);
        query(1, 1, "R3 pending after wrap");
        query(0, 1, "R3 pending at zero");
        query(62, 0, "R3 retired before wrap");
        wait_idle();
        query(1, 0, "R3 retired after wrap");
        for (int i = 0; i < 3; i++) release_one(0);

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule